// File: doc/BRIEF.md
# Load-Store Address Generation Unit

This block works out the byte address that a load or store presents to memory. It also works out the value that the base register holds afterwards. A request carries the following fields:

- a base register value and its identity (which register file and which index),
- a modification form,
- an offset source (an implicit one-element step, a short constant, an index register, or a long constant),
- an access size.

The offset is always scaled by the access size before it is used. Pre-modifying forms access memory at the modified address. Post-modifying forms access memory at the original base. Both kinds return the modified value for write-back.

Circular addressing confines the modification to a power-of-two block. The bits of the base above the block boundary are kept as they are, and only the low bits wrap. Circular behaviour is honoured only for a small set of base registers; every other base is treated linearly. The long constant offset is legal only from two dedicated pointer registers, and it never changes the base.

Results are registered, so they appear one clock after the request is accepted. The register file and the memory port sit outside this unit.

Top module: `agu_top`

## Requirements
- R1: While rst_ni is low, and after its release until the first request, valid_o, wb_en_o and illegal_o are 0, and addr_o and base_new_o are zero.
- R2: The offset is shifted left by the size code on size_i. Code 0 is a byte (shift 0), code 1 is a halfword (shift 1), and codes 2 and 3 are a word (shift 2). A word access with offset 9 therefore lands on base + 36.
- R3: ofs_src_i selects the offset. Code 0 is an implicit step of one element for the modifying forms and zero for the unmodified forms. Code 1 is cst_i[4:0]. Code 2 is idx_val_i. Code 3 is the long constant cst_i[14:0].
- R4: form_i codes are as follows. Code 0 adds the offset without modification. Code 1 subtracts it without modification. Codes 2 and 3 are pre-increment and pre-decrement. Codes 4 and 5 are post-increment and post-decrement. Codes 6 and 7 behave as code 0. All arithmetic is modulo 2^32.
- R5: A pre form drives addr_o and base_new_o with the modified value and sets wb_en_o.
- R6: A post form drives addr_o with the unmodified base, drives base_new_o with the modified value, and sets wb_en_o.
- R7: An unmodified form drives addr_o with base ± scaled offset, clears wb_en_o, and returns base_new_o equal to the base.
- R8: The long constant is accepted only when base_file_i is 1 and base_reg_i is 14 or 15. In that case addr_o is the base plus the scaled constant, base_new_o is the base, wb_en_o is 0, and form_i is ignored. For any other base, illegal_o is 1, addr_o is the base, and wb_en_o is 0.
- R9: When circ_en_i is 1 and base_reg_i is 4 to 7 in either file, let k be circ_log2_i. Every computed address and modified value keeps the base's bits k and above. Its low k bits are (base ± offset) mod 2^k.
- R10: circ_en_i has no effect on any other base register or on a long-constant request; such requests use the linear result.
- R11: Results appear one cycle after a request. valid_o follows req_valid_i by one cycle, and wb_en_o and illegal_o are 0 whenever valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| base_file_i | input | 1 | Register file of the base (0 = first, 1 = second) |
| base_reg_i | input | 5 | Base register index within its file |
| base_val_i | input | 32 | Current base register value |
| form_i | input | 3 | Modification form code |
| ofs_src_i | input | 2 | Offset source code |
| cst_i | input | 15 | Constant field (short uses bits 4:0) |
| idx_val_i | input | 32 | Index register value |
| size_i | input | 2 | Access size code |
| circ_en_i | input | 1 | Circular addressing requested |
| circ_log2_i | input | 5 | log2 of circular block size in bytes |
| valid_o | output | 1 | Result valid |
| addr_o | output | 32 | Effective byte address |
| base_new_o | output | 32 | Base value for write-back |
| wb_en_o | output | 1 | Base write-back enable |
| illegal_o | output | 1 | Long constant used on a disallowed base |

## Verification
The delicate case is a post-modification and a circular wrap landing in the same request. In that case the access must still use the untouched base, while the write-back value folds round the block edge. The mirror case is a pre-decrement that crosses the bottom of the block, so the access itself lands at the block top. Both are provoked with directed vectors at each block edge, and random vectors also mix eligible registers, sizes and block sizes. Each result is judged one cycle later against a behavioural model that uses modulo and remainder arithmetic rather than bit masks.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam logic [2:0] FORM_PLUS    = 3'd0;
  localparam logic [2:0] FORM_MINUS   = 3'd1;
  localparam logic [2:0] FORM_PREINC  = 3'd2;
  localparam logic [2:0] FORM_PREDEC  = 3'd3;
  localparam logic [2:0] FORM_POSTINC = 3'd4;
  localparam logic [2:0] FORM_POSTDEC = 3'd5;

  localparam logic [1:0] SRC_UNIT  = 2'd0;
  localparam logic [1:0] SRC_SHORT = 2'd1;
  localparam logic [1:0] SRC_INDEX = 2'd2;
  localparam logic [1:0] SRC_LONG  = 2'd3;

  typedef struct packed {
    logic sub;      // subtract offset
    logic pre;      // access at modified address
    logic post;     // access at base
    logic unit;     // implicit step is one element
    logic is_long;  // long constant request
    logic illegal;  // long constant on disallowed base
    logic circ;     // circular wrap applies
  } agu_ctrl_t;
endpackage

// File: rtl/agu_decode.sv
module agu_decode
  import agu_pkg::*;
#(
  parameter int RW      = 5,
  parameter int CIRC_LO = 4,
  parameter int CIRC_HI = 7,
  parameter int LONG_A  = 14,
  parameter int LONG_B  = 15
) (
  input  logic          base_file_i,
  input  logic [RW-1:0] base_reg_i,
  input  logic [2:0]    form_i,
  input  logic [1:0]    ofs_src_i,
  input  logic          circ_en_i,
  output agu_ctrl_t     ctrl_o
);
  logic is_long, long_ok, in_circ_set;

  assign is_long     = (ofs_src_i == SRC_LONG);
  assign long_ok     = base_file_i &&
                       ((base_reg_i == RW'(LONG_A)) || (base_reg_i == RW'(LONG_B)));
  assign in_circ_set = (base_reg_i >= RW'(CIRC_LO)) && (base_reg_i <= RW'(CIRC_HI));

  always_comb begin
    ctrl_o         = '0;
    ctrl_o.is_long = is_long;
    ctrl_o.illegal = is_long && !long_ok;
    if (!is_long) begin
      ctrl_o.circ = circ_en_i && in_circ_set;
      unique case (form_i)
        FORM_MINUS:   ctrl_o.sub = 1'b1;
        FORM_PREINC:  begin ctrl_o.pre = 1'b1; ctrl_o.unit = 1'b1; end
        FORM_PREDEC:  begin ctrl_o.pre = 1'b1; ctrl_o.unit = 1'b1; ctrl_o.sub = 1'b1; end
        FORM_POSTINC: begin ctrl_o.post = 1'b1; ctrl_o.unit = 1'b1; end
        FORM_POSTDEC: begin ctrl_o.post = 1'b1; ctrl_o.unit = 1'b1; ctrl_o.sub = 1'b1; end
        default:      ctrl_o.sub = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/agu_offset.sv
module agu_offset
  import agu_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 15,
  parameter int SW = 5
) (
  input  logic [1:0]    ofs_src_i,
  input  logic          unit_i,
  input  logic [CW-1:0] cst_i,
  input  logic [AW-1:0] idx_val_i,
  input  logic [1:0]    size_i,
  output logic [AW-1:0] ofs_o
);
  logic [AW-1:0] raw;
  logic [1:0]    sh;

  always_comb begin
    unique case (ofs_src_i)
      SRC_UNIT:  raw = AW'(unit_i);
      SRC_SHORT: raw = {{(AW-SW){1'b0}}, cst_i[SW-1:0]};
      SRC_INDEX: raw = idx_val_i;
      default:   raw = {{(AW-CW){1'b0}}, cst_i};
    endcase
  end

  assign sh    = (size_i == 2'd3) ? 2'd2 : size_i;
  assign ofs_o = raw << sh;
endmodule

// File: rtl/agu_circ_add.sv
module agu_circ_add #(
  parameter int AW = 32,
  parameter int KW = 5
) (
  input  logic [AW-1:0] base_i,
  input  logic [AW-1:0] ofs_i,
  input  logic          sub_i,
  input  logic          circ_i,
  input  logic [KW-1:0] k_i,
  output logic [AW-1:0] res_o
);
  logic [AW-1:0] sum;

  assign sum = sub_i ? (base_i - ofs_i) : (base_i + ofs_i);

  // bits at or above the block boundary hold the base in circular mode
  for (genvar i = 0; i < AW; i++) begin : g_bit
    logic keep;
    assign keep     = circ_i && (32'(i) >= 32'(k_i));
    assign res_o[i] = keep ? base_i[i] : sum[i];
  end
endmodule

// File: rtl/agu_top.sv
module agu_top
  import agu_pkg::*;
#(
  parameter int AW      = 32,
  parameter int CW      = 15,
  parameter int SW      = 5,
  parameter int RW      = 5,
  parameter int CIRC_LO = 4,
  parameter int CIRC_HI = 7,
  parameter int LONG_A  = 14,
  parameter int LONG_B  = 15,
  localparam int KW     = $clog2(AW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic          base_file_i,
  input  logic [RW-1:0] base_reg_i,
  input  logic [AW-1:0] base_val_i,
  input  logic [2:0]    form_i,
  input  logic [1:0]    ofs_src_i,
  input  logic [CW-1:0] cst_i,
  input  logic [AW-1:0] idx_val_i,
  input  logic [1:0]    size_i,
  input  logic          circ_en_i,
  input  logic [KW-1:0] circ_log2_i,
  output logic          valid_o,
  output logic [AW-1:0] addr_o,
  output logic [AW-1:0] base_new_o,
  output logic          wb_en_o,
  output logic          illegal_o
);
  agu_ctrl_t     ctrl;
  logic [AW-1:0] ofs, modv, addr_d, base_d;
  logic          wb_d;

  agu_decode #(
    .RW(RW), .CIRC_LO(CIRC_LO), .CIRC_HI(CIRC_HI), .LONG_A(LONG_A), .LONG_B(LONG_B)
  ) i_decode (
    .base_file_i(base_file_i),
    .base_reg_i (base_reg_i),
    .form_i     (form_i),
    .ofs_src_i  (ofs_src_i),
    .circ_en_i  (circ_en_i),
    .ctrl_o     (ctrl)
  );

  agu_offset #(.AW(AW), .CW(CW), .SW(SW)) i_offset (
    .ofs_src_i(ofs_src_i),
    .unit_i   (ctrl.unit),
    .cst_i    (cst_i),
    .idx_val_i(idx_val_i),
    .size_i   (size_i),
    .ofs_o    (ofs)
  );

  agu_circ_add #(.AW(AW), .KW(KW)) i_add (
    .base_i(base_val_i),
    .ofs_i (ofs),
    .sub_i (ctrl.sub),
    .circ_i(ctrl.circ),
    .k_i   (circ_log2_i),
    .res_o (modv)
  );

  always_comb begin
    wb_d   = ctrl.pre || ctrl.post;
    base_d = wb_d ? modv : base_val_i;
    if (ctrl.illegal || ctrl.post) addr_d = base_val_i;
    else                           addr_d = modv;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o    <= 1'b0;
      wb_en_o    <= 1'b0;
      illegal_o  <= 1'b0;
      addr_o     <= '0;
      base_new_o <= '0;
    end else begin
      valid_o   <= req_valid_i;
      wb_en_o   <= req_valid_i && wb_d;
      illegal_o <= req_valid_i && ctrl.illegal;
      if (req_valid_i) begin
        addr_o     <= addr_d;
        base_new_o <= base_d;
      end
    end
  end
endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
  parameter int AW      = 32,
  parameter int RW      = 5,
  parameter int KW      = 5,
  parameter int CIRC_LO = 4,
  parameter int CIRC_HI = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_valid_i,
  input logic [RW-1:0] base_reg_i,
  input logic [AW-1:0] base_val_i,
  input logic [2:0]    form_i,
  input logic [1:0]    ofs_src_i,
  input logic          circ_en_i,
  input logic [KW-1:0] circ_log2_i,
  input logic          valid_o,
  input logic [AW-1:0] addr_o,
  input logic [AW-1:0] base_new_o,
  input logic          wb_en_o,
  input logic          illegal_o
);
  logic not_long, is_pre, is_post, is_nomod, circ_req;
  assign not_long = (ofs_src_i != 2'd3);
  assign is_pre   = (form_i == 3'd2) || (form_i == 3'd3);
  assign is_post  = (form_i == 3'd4) || (form_i == 3'd5);
  assign is_nomod = !is_pre && !is_post;
  assign circ_req = circ_en_i && not_long &&
                    (base_reg_i >= RW'(CIRC_LO)) && (base_reg_i <= RW'(CIRC_HI));

  a_r11_valid_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> valid_o);
  a_r11_valid_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !valid_o);
  a_r11_flags_need_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_en_o || illegal_o) |-> valid_o);
  a_r5_pre_same: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && not_long && is_pre |=> wb_en_o && (addr_o == base_new_o));
  a_r6_post_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && not_long && is_post |=> wb_en_o && (addr_o == $past(base_val_i)));
  a_r7_nomod_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && not_long && is_nomod |=> !wb_en_o && (base_new_o == $past(base_val_i)));
  a_r8_long_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !not_long |=> !wb_en_o && (base_new_o == $past(base_val_i)));
  a_r9_upper_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && circ_req |=>
      (((base_new_o ^ $past(base_val_i)) >> $past(circ_log2_i)) == '0) &&
      (((addr_o ^ $past(base_val_i)) >> $past(circ_log2_i)) == '0));
endmodule

bind agu_top agu_chk #(
  .AW(AW), .RW(RW), .KW(KW), .CIRC_LO(CIRC_LO), .CIRC_HI(CIRC_HI)
) i_agu_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .base_reg_i (base_reg_i),
  .base_val_i (base_val_i),
  .form_i     (form_i),
  .ofs_src_i  (ofs_src_i),
  .circ_en_i  (circ_en_i),
  .circ_log2_i(circ_log2_i),
  .valid_o    (valid_o),
  .addr_o     (addr_o),
  .base_new_o (base_new_o),
  .wb_en_o    (wb_en_o),
  .illegal_o  (illegal_o)
);

// File: tb/test_agu_top.sv
module test_agu_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        base_file_i = 1'b0;
  logic [4:0]  base_reg_i = '0;
  logic [31:0] base_val_i = '0;
  logic [2:0]  form_i = '0;
  logic [1:0]  ofs_src_i = '0;
  logic [14:0] cst_i = '0;
  logic [31:0] idx_val_i = '0;
  logic [1:0]  size_i = '0;
  logic        circ_en_i = 1'b0;
  logic [4:0]  circ_log2_i = '0;
  logic        valid_o, wb_en_o, illegal_o;
  logic [31:0] addr_o, base_new_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  agu_top i_agu_top (.*);

  longint unsigned e_addr, e_base;
  bit e_wb, e_ill;
  string e_tag;

  // behavioural model: modulo arithmetic, no masks
  task automatic model();
    longint unsigned m32 = 64'h1_0000_0000;
    longint unsigned base = base_val_i;
    longint unsigned unit, off, modv, blk;
    bit pre, post, neg, circ;
    unit = (size_i == 0) ? 1 : (size_i == 1) ? 2 : 4;
    pre  = (form_i == 2) || (form_i == 3);
    post = (form_i == 4) || (form_i == 5);
    neg  = (form_i == 1) || (form_i == 3) || (form_i == 5);
    e_ill = 0;
    if (ofs_src_i == 3) begin
      e_base = base; e_wb = 0;
      if (base_file_i && (base_reg_i == 14 || base_reg_i == 15)) begin
        e_addr = (base + cst_i * unit) % m32; e_tag = "R8";
      end else begin
        e_addr = base; e_ill = 1; e_tag = "R8";
      end
      if (circ_en_i && base_reg_i >= 4 && base_reg_i <= 7) e_tag = "R10";
      return;
    end
    case (ofs_src_i)
      0: off = (pre || post) ? 1 : 0;
      1: off = cst_i % 32;
      default: off = idx_val_i;
    endcase
    off  = (off * unit) % m32;
    modv = neg ? (base + m32 - off) % m32 : (base + off) % m32;
    circ = circ_en_i && base_reg_i >= 4 && base_reg_i <= 7;
    if (circ) begin
      blk  = longint'(1) << circ_log2_i;
      modv = base - (base % blk) + (modv % blk);
    end
    if (pre)       begin e_addr = modv; e_base = modv; e_wb = 1; e_tag = "R5"; end
    else if (post) begin e_addr = base; e_base = modv; e_wb = 1; e_tag = "R6"; end
    else           begin e_addr = modv; e_base = base; e_wb = 0; e_tag = "R7"; end
    if (circ) e_tag = "R9";
    else if (circ_en_i) e_tag = "R10";
  endtask

  // inputs are set at a negedge; result is sampled one negedge later
  task automatic apply(input string tag);
    req_valid_i = 1'b1;
    model();
    if (tag != "") e_tag = tag;
    @(negedge clk_i);
    n_chk++;
    if (valid_o !== 1'b1 || addr_o !== e_addr[31:0] || base_new_o !== e_base[31:0] ||
        wb_en_o !== e_wb || illegal_o !== e_ill) begin
      n_fail++;
      $display("FAIL %s: v=%b a=%h b=%h wb=%b ill=%b, expected v=1 a=%h b=%h wb=%b ill=%b",
               e_tag, valid_o, addr_o, base_new_o, wb_en_o, illegal_o,
               e_addr[31:0], e_base[31:0], e_wb, e_ill);
    end
  endtask

  task automatic idle();
    req_valid_i = 1'b0;
    @(negedge clk_i);
    n_chk++;
    if (valid_o !== 1'b0 || wb_en_o !== 1'b0 || illegal_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R11: v=%b wb=%b ill=%b, expected all 0", valid_o, wb_en_o, illegal_o);
    end
  endtask

  task automatic set(input bit f, input int r, input logic [31:0] b, input int fm,
                     input int src, input int c, input logic [31:0] ix, input int sz,
                     input bit ce, input int k);
    base_file_i = f; base_reg_i = 5'(r); base_val_i = b; form_i = 3'(fm);
    ofs_src_i = 2'(src); cst_i = 15'(c); idx_val_i = ix; size_i = 2'(sz);
    circ_en_i = ce; circ_log2_i = 5'(k);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    n_chk++;
    if (valid_o !== 0 || wb_en_o !== 0 || illegal_o !== 0 || addr_o !== 0 || base_new_o !== 0) begin
      n_fail++;
      $display("FAIL R1: v=%b wb=%b ill=%b a=%h b=%h, expected zeros",
               valid_o, wb_en_o, illegal_o, addr_o, base_new_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    idle();
    // R2: word, short constant 9, pre-increment -> base + 36
    set(0, 4, 32'h0000_1000, 2, 1, 9, 0, 2, 0, 0);        apply("R2");
    set(0, 4, 32'h0000_1000, 0, 1, 9, 0, 1, 0, 0);        apply("R2");
    set(0, 4, 32'h0000_1000, 1, 1, 9, 0, 0, 0, 0);        apply("R2");
    set(0, 4, 32'h0000_1000, 0, 1, 9, 0, 3, 0, 0);        apply("R2");
    // R3: sources; short uses only 5 bits of the constant
    set(1, 9, 32'h0000_2000, 4, 0, 0, 0, 1, 0, 0);        apply("R3");
    set(1, 9, 32'h0000_2000, 0, 0, 0, 0, 2, 0, 0);        apply("R3");
    set(1, 9, 32'h0000_2000, 0, 1, 15'h7FE3, 0, 0, 0, 0); apply("R3");
    set(1, 9, 32'h0000_2000, 3, 2, 0, 32'h10, 2, 0, 0);   apply("R3");
    // R4: reserved forms and wrap modulo 2^32
    set(0, 1, 32'h0000_0010, 6, 1, 3, 0, 0, 0, 0);        apply("R4");
    set(0, 1, 32'h0000_0010, 7, 1, 3, 0, 0, 0, 0);        apply("R4");
    set(0, 1, 32'h0000_0002, 5, 2, 0, 32'h4, 2, 0, 0);    apply("R4");
    // R8: long constant legal and illegal
    set(1, 15, 32'h8000_0000, 2, 3, 15'h7FFF, 0, 2, 0, 0); apply("R8");
    set(1, 14, 32'h8000_0000, 5, 3, 100, 0, 1, 0, 0);      apply("R8");
    set(0, 14, 32'h8000_0000, 2, 3, 100, 0, 1, 0, 0);      apply("R8");
    set(1, 13, 32'h8000_0000, 0, 3, 100, 0, 1, 0, 0);      apply("R8");
    idle();
    // R9: post-increment wrapping at top edge, pre-decrement at bottom edge
    set(0, 5, 32'h1000_003C, 4, 0, 0, 0, 2, 1, 6);        apply("R9");
    set(1, 7, 32'h1000_0000, 3, 0, 0, 0, 2, 1, 6);        apply("R9");
    set(1, 4, 32'h1000_0038, 2, 1, 5, 0, 2, 1, 6);        apply("R9");
    set(0, 6, 32'hABCD_0002, 1, 2, 0, 32'h7, 0, 1, 3);    apply("R9");
    // R10: circular ignored outside the set and for the long constant
    set(0, 8, 32'h1000_003C, 4, 0, 0, 0, 2, 1, 6);        apply("R10");
    set(0, 3, 32'h1000_0000, 3, 0, 0, 0, 2, 1, 6);        apply("R10");
    set(1, 15, 32'h1000_003C, 0, 3, 4, 0, 2, 1, 6);       apply("R10");
    idle();
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] r = 5'($urandom_range(0, 3) == 0 ? $urandom_range(4, 7) :
                         $urandom_range(0, 31));
      set(1'($urandom), int'(r), $urandom, int'($urandom_range(0, 7)),
          int'($urandom_range(0, 3)), int'($urandom_range(0, 32767)), $urandom,
          int'($urandom_range(0, 3)), 1'($urandom), int'($urandom_range(0, 31)));
      if ($urandom_range(0, 9) == 0) idle();
      else apply("");
    end
    idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule